// File: doc/BRIEF.md
# Randomized XOR Matrix Hash

This block turns sliding 10-byte windows of payload data into short hash values. Up to four windows arrive in parallel on every clock, each with its own valid flag. Every hash output bit is the parity of the window bits picked out by a per-bit 80-bit mask. Together the masks form a binary matrix, and the hash is a linear map over GF(2). The matrix is random and is chosen when the system is configured, so an attacker cannot work out which inputs will collide. The hash feeds a downstream counter array: the upper hash bits select a bank and the lower bits select a counter.

Mask rows are written one at a time through a configuration port that takes a row index and an 80-bit mask. This happens while hashing is switched off. The random values come from outside the block. All four lanes share the same matrix. The result and the valid flags are registered, so a window presented at one clock edge produces its hash after that edge.

Top module: `xor_matrix_hash`

## Requirements
- R1: After a synchronous active-low reset, every out_valid bit is 0, out_hash is 0 and every mask row is zero. With zero masks, any window hashes to 0.
- R2: Bit b of a lane's hash equals the XOR of all window bits i for which bit i of mask row b is 1. Window bit 0 is the LSB of the lane's 80-bit slice.
- R3: A window sampled at clock edge n shows up on out_hash after edge n and holds until the next edge.
- R4: Lane j takes its window from in_window[j*80 +: 80] and drives out_hash[j*HASH_W +: HASH_W]. All lanes use the same matrix, so equal windows give equal hashes.
- R5: out_valid[j] after edge n equals in_valid[j] AND hash_en, both sampled at edge n. When hash_en is 0, all lanes come out invalid.
- R6: A mask write (cfg_we=1) sampled while hash_en is 1 is ignored, and the matrix keeps its old contents.
- R7: A mask write whose cfg_row is HASH_W or larger is ignored, and no row changes.
- R8: An accepted write replaces the whole addressed row. The new row is used for windows sampled from the next edge onward, and the last write to a row wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| hash_en | input | 1 | Hashing enabled; blocks mask writes |
| cfg_we | input | 1 | Mask row write strobe |
| cfg_row | input | ROW_W (4) | Index of the mask row to write |
| cfg_mask | input | WIN_W (80) | New mask row contents |
| in_valid | input | LANES (4) | Per-lane window valid |
| in_window | input | LANES*WIN_W (320) | Packed lane windows, lane 0 in the low bits |
| out_valid | output | LANES (4) | Per-lane hash valid, one cycle later |
| out_hash | output | LANES*HASH_W (60) | Packed lane hashes, lane 0 in the low bits |

## Verification
The bench first loads every row with random masks, then hashes all-ones, all-zero, walking-bit and random windows. A swapped row index or a misaligned lane slice therefore shows up as a wrong bit in some lane. It then issues a write while hashing is on and a write to the unused row index 15, and hashes afterwards. A design that obeyed either write would return hashes built from the altered row. Back-to-back writes to one row, followed at once by a window, catch a design that keeps the first value or applies the write a cycle late. Mixed valid patterns, and windows sent with hashing off, catch a design that drops or invents valid flags.

// File: rtl/xh_pkg.sv
// Shared sizing for the XOR matrix hash.
// Assumes: callers override widths through the top parameters only.
package xh_pkg;
    localparam int XH_LANES  = 4;
    localparam int XH_WIN_W  = 80;
    localparam int XH_HASH_W = 15;

    // Width needed to index HASH_W mask rows (at least one bit).
    function automatic int xh_row_bits(input int rows);
        int w;
        w = 1;
        while ((1 << w) < rows) w++;
        return w;
    endfunction
endpackage

// File: rtl/xh_mask_bank.sv
// Mask matrix storage: HASH_W rows of WIN_W bits, one row per hash bit.
// Assumes: writes are only meant to land while hashing is off; a write that
// arrives while hashing is on, or that names a row past the end, is dropped.
module xh_mask_bank #(
    parameter int WIN_W  = xh_pkg::XH_WIN_W,
    parameter int HASH_W = xh_pkg::XH_HASH_W,
    parameter int ROW_W  = xh_pkg::xh_row_bits(HASH_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hash_en,
    input  logic                    cfg_we,
    input  logic [ROW_W-1:0]        cfg_row,
    input  logic [WIN_W-1:0]        cfg_mask,
    output logic [HASH_W*WIN_W-1:0] masks
);
    localparam logic [ROW_W:0] ROW_LIMIT = (ROW_W+1)'(HASH_W);

    logic wr_ok;

    // Qualify a write: strobe present, hashing idle, row in range.
    always_comb begin
        wr_ok = cfg_we && !hash_en && ({1'b0, cfg_row} < ROW_LIMIT);
    end

    for (genvar r = 0; r < HASH_W; r++) begin : g_row
        logic [WIN_W-1:0] row_q;

        // Hold one mask row; cleared by reset, replaced on a matching write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                row_q <= '0;
            end else if (wr_ok && (cfg_row == ROW_W'(r))) begin
                row_q <= cfg_mask;
            end
        end

        assign masks[r*WIN_W +: WIN_W] = row_q;
    end
endmodule

// File: rtl/xh_lane.sv
// One hash lane: parity of (mask row AND window) per output bit, registered.
// Assumes: the hash of an invalid lane is don't-care downstream; it is still
// computed so the datapath carries no extra gating.
module xh_lane #(
    parameter int WIN_W  = xh_pkg::XH_WIN_W,
    parameter int HASH_W = xh_pkg::XH_HASH_W
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hash_en,
    input  logic                    win_valid,
    input  logic [WIN_W-1:0]        window,
    input  logic [HASH_W*WIN_W-1:0] masks,
    output logic                    hash_valid,
    output logic [HASH_W-1:0]       hash
);
    logic [HASH_W-1:0] parity;

    for (genvar b = 0; b < HASH_W; b++) begin : g_bit
        // Reduce the selected window bits of row b to a single parity bit.
        always_comb begin
            parity[b] = ^(masks[b*WIN_W +: WIN_W] & window);
        end
    end

    // Register hash and qualified valid: one cycle of latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hash_valid <= 1'b0;
            hash       <= '0;
        end else begin
            hash_valid <= win_valid && hash_en;
            hash       <= parity;
        end
    end
endmodule

// File: rtl/xor_matrix_hash.sv
// Top: LANES parallel randomized XOR hashes sharing one mask matrix.
// Assumes: the matrix is loaded with hash_en low before traffic; lane j's
// window occupies in_window[j*WIN_W +: WIN_W], lane 0 in the low bits.
module xor_matrix_hash #(
    parameter int LANES  = xh_pkg::XH_LANES,
    parameter int WIN_W  = xh_pkg::XH_WIN_W,
    parameter int HASH_W = xh_pkg::XH_HASH_W,
    parameter int ROW_W  = xh_pkg::xh_row_bits(HASH_W)
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    hash_en,
    input  logic                    cfg_we,
    input  logic [ROW_W-1:0]        cfg_row,
    input  logic [WIN_W-1:0]        cfg_mask,
    input  logic [LANES-1:0]        in_valid,
    input  logic [LANES*WIN_W-1:0]  in_window,
    output logic [LANES-1:0]        out_valid,
    output logic [LANES*HASH_W-1:0] out_hash
);
    logic [HASH_W*WIN_W-1:0] masks;

    xh_mask_bank #(
        .WIN_W (WIN_W),
        .HASH_W(HASH_W),
        .ROW_W (ROW_W)
    ) bank_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .hash_en (hash_en),
        .cfg_we  (cfg_we),
        .cfg_row (cfg_row),
        .cfg_mask(cfg_mask),
        .masks   (masks)
    );

    for (genvar j = 0; j < LANES; j++) begin : g_lane
        xh_lane #(
            .WIN_W (WIN_W),
            .HASH_W(HASH_W)
        ) lane_i (
            .clk       (clk),
            .rst_n     (rst_n),
            .hash_en   (hash_en),
            .win_valid (in_valid[j]),
            .window    (in_window[j*WIN_W +: WIN_W]),
            .masks     (masks),
            .hash_valid(out_valid[j]),
            .hash      (out_hash[j*HASH_W +: HASH_W])
        );
    end
endmodule

// File: rtl/xh_checker.sv
// Checker for xor_matrix_hash, attached by bind below.
// Assumes: same parameter values as the bound top.
module xh_checker #(
    parameter int LANES  = xh_pkg::XH_LANES,
    parameter int WIN_W  = xh_pkg::XH_WIN_W,
    parameter int HASH_W = xh_pkg::XH_HASH_W
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    hash_en,
    input logic [LANES-1:0]        in_valid,
    input logic [LANES*WIN_W-1:0]  in_window,
    input logic [LANES-1:0]        out_valid,
    input logic [LANES*HASH_W-1:0] out_hash
);
    logic seen;

    // Mark that at least one edge has passed with reset released.
    always_ff @(posedge clk) begin
        seen <= rst_n;
    end

    AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |=> (out_valid == '0)); // R1

    AST_OFF_INVALID: assert property (@(posedge clk) disable iff (!rst_n)
        !hash_en |=> (out_valid == '0)); // R5

    AST_HASH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !seen)
        (hash_en && $past(hash_en) && $stable(in_window)) |=> $stable(out_hash)); // R6

    for (genvar j = 1; j < LANES; j++) begin : g_pair
        AST_LANES_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
            (in_window[j*WIN_W +: WIN_W] == in_window[WIN_W-1:0])
            |=> (out_hash[j*HASH_W +: HASH_W] == out_hash[HASH_W-1:0])); // R4
    end
endmodule

bind xor_matrix_hash xh_checker #(
    .LANES (LANES),
    .WIN_W (WIN_W),
    .HASH_W(HASH_W)
) chk_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .hash_en  (hash_en),
    .in_valid (in_valid),
    .in_window(in_window),
    .out_valid(out_valid),
    .out_hash (out_hash)
);

// File: tb/xor_matrix_hash_tb_top.sv
// Scoreboard bench: the driver pushes expected results, the monitor pops them.
module xor_matrix_hash_tb_top;
    localparam int L  = 4;
    localparam int W  = 80;
    localparam int K  = 15;
    localparam int RW = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           hash_en = 1'b0;
    logic           cfg_we = 1'b0;
    logic [RW-1:0]  cfg_row = '0;
    logic [W-1:0]   cfg_mask = '0;
    logic [L-1:0]   in_valid = '0;
    logic [L*W-1:0] in_window = '0;
    logic [L-1:0]   out_valid;
    logic [L*K-1:0] out_hash;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [W-1:0]   model_mask [K];
    logic [31:0]    rng = 32'h1234_5678;

    logic [L-1:0]   q_valid [$];
    logic [L*K-1:0] q_hash  [$];
    string          q_tag   [$];

    always #10 clk = ~clk;

    xor_matrix_hash dut_i (
        .clk(clk), .rst_n(rst_n), .hash_en(hash_en), .cfg_we(cfg_we),
        .cfg_row(cfg_row), .cfg_mask(cfg_mask), .in_valid(in_valid),
        .in_window(in_window), .out_valid(out_valid), .out_hash(out_hash)
    );

    function automatic logic [31:0] next_rnd();
        rng = rng ^ (rng << 13);
        rng = rng ^ (rng >> 17);
        rng = rng ^ (rng << 5);
        return rng;
    endfunction

    function automatic logic [W-1:0] rnd_win();
        logic [95:0] v;
        v = {next_rnd(), next_rnd(), next_rnd()};
        return v[W-1:0];
    endfunction

    function automatic logic [K-1:0] ref_hash(input logic [W-1:0] win);
        logic [K-1:0] h;
        for (int b = 0; b < K; b++) h[b] = ^(model_mask[b] & win);
        return h;
    endfunction

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Driver: one cycle of stimulus; expected result computed from the model.
    task automatic drive(input string tag, input logic en, input logic [L-1:0] v,
                         input logic [L*W-1:0] wins, input logic we,
                         input logic [RW-1:0] row, input logic [W-1:0] msk);
        logic [L*K-1:0] eh;
        @(negedge clk);
        hash_en = en; in_valid = v; in_window = wins;
        cfg_we = we; cfg_row = row; cfg_mask = msk;
        for (int j = 0; j < L; j++) eh[j*K +: K] = ref_hash(wins[j*W +: W]);
        q_valid.push_back(en ? v : '0);
        q_hash.push_back(eh);
        q_tag.push_back(tag);
        if (we && !en && (int'(row) < K)) model_mask[row] = msk;
    endtask

    task automatic write_row(input string tag, input logic en, input logic [RW-1:0] row,
                             input logic [W-1:0] msk);
        drive(tag, en, '0, '0, 1'b1, row, msk);
    endtask

    task automatic hash4(input string tag, input logic [L-1:0] v, input logic [L*W-1:0] wins);
        drive(tag, 1'b1, v, wins, 1'b0, '0, '0);
    endtask

    function automatic logic [L*W-1:0] rnd4();
        return {rnd_win(), rnd_win(), rnd_win(), rnd_win()};
    endfunction

    // Monitor: the result for the item pushed at the previous falling edge (R3).
    always @(posedge clk) begin
        #1;
        if (q_valid.size() > 0) begin
            logic [L-1:0]   ev;
            logic [L*K-1:0] eh;
            string          tg;
            ev = q_valid.pop_front();
            eh = q_hash.pop_front();
            tg = q_tag.pop_front();
            check({tg, " R5 valid"}, 64'(out_valid), 64'(ev));
            for (int j = 0; j < L; j++)
                if (ev[j]) check({tg, " R3 hash"}, 64'(out_hash[j*K +: K]), 64'(eh[j*K +: K]));
        end
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [W-1:0] keep;
        for (int b = 0; b < K; b++) model_mask[b] = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #2;
        // R1: reset state at the ports
        check("R1 reset valid", 64'(out_valid), 64'd0);
        check("R1 reset hash", 64'(out_hash), 64'd0);
        // R1: zero masks give zero hash
        hash4("R1 zero-mask", 4'hF, rnd4());
        // R2/R8: load random rows
        for (int b = 0; b < K; b++) write_row("R8 load", 1'b0, RW'(b), rnd_win());
        hash4("R2 ones", 4'hF, {L*W{1'b1}});
        hash4("R2 zeros", 4'hF, '0);
        for (int i = 0; i < W; i += 7) begin
            logic [W-1:0] w1;
            w1 = '0; w1[i] = 1'b1;
            hash4("R2 walk", 4'hF, {w1, ~w1, w1 << 1, w1});
        end
        for (int i = 0; i < 40; i++) hash4("R2 random", 4'hF, rnd4());
        // R4: identical windows on all lanes
        keep = rnd_win();
        hash4("R4 equal", 4'hF, {keep, keep, keep, keep});
        // R5: valid patterns and hashing off
        hash4("R5 mix", 4'b1010, rnd4());
        hash4("R5 mix", 4'b0001, rnd4());
        drive("R5 off", 1'b0, 4'hF, rnd4(), 1'b0, '0, '0);
        hash4("R5 none", 4'b0000, rnd4());
        // R6: write while enabled is dropped
        write_row("R6 en-write", 1'b1, 4'd3, rnd_win());
        keep = {W{1'b1}};
        hash4("R6 after", 4'hF, {keep, keep, rnd_win(), rnd_win()});
        // R7: out-of-range row dropped
        write_row("R7 row15", 1'b0, 4'd15, rnd_win());
        hash4("R7 after", 4'hF, {keep, rnd_win(), rnd_win(), keep});
        // R8: last write wins, visible on the very next window
        write_row("R8 first", 1'b0, 4'd0, rnd_win());
        write_row("R8 second", 1'b0, 4'd0, rnd_win());
        hash4("R8 next", 4'hF, {keep, rnd_win(), rnd_win(), rnd_win()});
        write_row("R8 last", 1'b0, 4'd14, {W{1'b1}});
        hash4("R8 row14", 4'hF, rnd4());
        drive("idle", 1'b0, '0, '0, 1'b0, '0, '0);
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule